// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Vector Controller

This block combines two eight-line priority slices into a sixteen-line interrupt system. The upper slice (the slave) serves request lines 8 to 15. When it has a request that can be served, it feeds line 2 of the lower slice (the master), which serves lines 0 to 7. A single interrupt output tells the processor that the master has a request that can be served.

The processor answers with a one-cycle acknowledge pulse. In that same cycle the block resolves the master. If the master's winner is the cascade line, it also resolves the slave. The block then moves the winning lines from pending to in-service and, one cycle later, returns an 8-bit vector together with the 4-bit global line number. When an acknowledge finds nothing to serve at either level, it returns line 7 of the level concerned as a spurious answer.

Each slice has its own small programming port, which the block passes straight through. Through it software sets the slice's mask, vector base, nesting mode and end-of-interrupt commands.

Top module: `cascadedIrqCtrl`

## Requirements
- R1: Request line n is handled by the slave when bit 3 of n is 1 and by the master otherwise. Bits 2:0 of n give the line inside that slice, and a served line's vector is that slice's base with the slice line in bits 2:0.
- R2: A request is latched on a 0-to-1 transition of its input. A line held high after it has been acknowledged and ended raises no new request.
- R3: Inside a slice the lowest line index has the highest priority. A pending unmasked line can be served only if its priority is above that of every in-service line of the slice.
- R4: `intOut` is high exactly when the master has a request that can be served. After reset it is low.
- R5: While the slave has a request that can be served, master request 2 is latched on the next clock. The external input on line 2 has no effect.
- R6: `ackReq` high for one cycle gives `ackValid` high for one cycle on the next clock. The master winner moves from pending to in-service. If that winner is line 2, the slave winner does the same, and the result is the slave base plus the slave line, with line number slave line + 8.
- R7: If the master winner is line 2 but the slave has nothing to serve, the result is the slave base plus 7, with line number 15.
- R8: If the master has nothing to serve at acknowledge time, the result is the master base plus 7, with line number 7, and no slice state changes.
- R9: Configuration address 0 writes the slice mask, where a 1 blocks that line. On the master, bit 2 blocks every slave line.
- R10: Configuration address 1 takes data bits 7:3 as the slice vector base. Data bits 2:0 are dropped.
- R11: Configuration address 3 clears the in-service bit selected by data bits 2:0.
- R12: Configuration address 2, data bit 0, on the master turns on nested mode. In this mode the master leaves its in-service bit 2 out of the priority comparison, so a higher slave request can interrupt a slave service.
- R13: After an end-of-interrupt write, a request that is still pending and can now be served raises `intOut` again, with no new input edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Request lines; bits 15:8 go to the slave |
| mCfgWr | input | 1 | Master configuration write strobe |
| mCfgAddr | input | 2 | Master configuration address (0 mask, 1 base, 2 mode, 3 end of interrupt) |
| mCfgData | input | 8 | Master configuration data |
| sCfgWr | input | 1 | Slave configuration write strobe |
| sCfgAddr | input | 2 | Slave configuration address |
| sCfgData | input | 8 | Slave configuration data |
| ackReq | input | 1 | Acknowledge pulse from the processor |
| intOut | output | 1 | Interrupt request to the processor |
| ackValid | output | 1 | Acknowledge result valid, one cycle |
| ackVector | output | 8 | Returned vector number |
| ackLine | output | 4 | Global line number of the result |

## Verification
The directed part targets the following cases.
- The spurious answer at the slave level, reached by masking a slave line after it has already latched master line 2. A design that re-checks the slave too early or too late returns a real slave vector or the master's line 2.
- The master spurious answer. A design that gets it wrong changes state or returns a vector from line 2.
- Nesting with and without the nested mode. Without the mode the interrupt must stay low; with it, the output must rise at once.
- A line held high, which a level-sensitive design would serve twice.
- Writes to the external line 2, which a design must not let through to the master.

A random phase of pulses, acknowledges, end-of-interrupt writes and mask writes is checked against a transaction-level model of both slices, which catches ordering errors between the master and slave updates.

// File: rtl/cascadePkg.sv
package cascadePkg;
  localparam int SLICE_LINES   = 8;
  localparam int NUM_SLICES    = 2;
  localparam int NUM_LINES     = SLICE_LINES * NUM_SLICES;
  localparam int LINE_W        = $clog2(SLICE_LINES);
  localparam int VEC_W         = 8;
  localparam int BASE_W        = VEC_W - LINE_W;
  localparam int CFG_ADDR_W    = 2;
  localparam int CASCADE_LINE  = 2;
  localparam int SPURIOUS_LINE = SLICE_LINES - 1;

  typedef enum logic [CFG_ADDR_W-1:0] {
    CFG_MASK = 2'd0,
    CFG_BASE = 2'd1,
    CFG_MODE = 2'd2,
    CFG_EOI  = 2'd3
  } cfgSel_e;

  // Strobe bundle from the control to one slice
  typedef struct packed {
    logic              ack;
    logic [LINE_W-1:0] line;
  } ackStrobe_t;

  typedef struct packed {
    logic              valid;
    logic [LINE_W-1:0] line;
  } pick_t;

  // Highest priority (lowest index) set bit
  function automatic pick_t lowestSet(input logic [SLICE_LINES-1:0] v);
    pick_t r;
    r.valid = 1'b0;
    r.line  = '0;
    for (int i = SLICE_LINES - 1; i >= 0; i--) begin
      if (v[i]) begin
        r.valid = 1'b1;
        r.line  = LINE_W'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/irqSlice.sv
module irqSlice
  import cascadePkg::*;
#(
  parameter bit IS_MASTER = 1'b0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [SLICE_LINES-1:0] reqLines,
  input  logic                   cascadeSet,
  input  logic                   cfgWr,
  input  logic [CFG_ADDR_W-1:0]  cfgAddr,
  input  logic [VEC_W-1:0]       cfgData,
  input  ackStrobe_t             ackStb,
  output logic                   hasReq,
  output logic [LINE_W-1:0]      winLine,
  output logic [BASE_W-1:0]      vecBase
);
  logic [SLICE_LINES-1:0] irrQ, isrQ, imrQ, lastQ;
  logic [BASE_W-1:0]      baseQ;
  logic                   nestQ;

  logic [SLICE_LINES-1:0] reqEff, casVec, rise, ackHot, eoiHot;
  logic [SLICE_LINES-1:0] pend, isrEff;
  pick_t                  pendPick, svcPick;

  // The master's cascade line follows the slave and never the pin
  always_comb begin
    if (IS_MASTER) begin
      reqEff = reqLines & ~(SLICE_LINES'(1) << CASCADE_LINE);
      casVec = SLICE_LINES'(cascadeSet) << CASCADE_LINE;
    end else begin
      reqEff = reqLines;
      casVec = '0;
    end
  end

  assign rise   = reqEff & ~lastQ;
  assign ackHot = ackStb.ack ? (SLICE_LINES'(1) << ackStb.line) : '0;
  assign eoiHot = (cfgWr && cfgAddr == CFG_EOI) ?
                  (SLICE_LINES'(1) << cfgData[LINE_W-1:0]) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ  <= '0;
      isrQ  <= '0;
      imrQ  <= '0;
      lastQ <= '0;
      baseQ <= '0;
      nestQ <= 1'b0;
    end else begin
      lastQ <= reqEff;
      irrQ  <= (irrQ & ~ackHot) | rise | casVec;
      isrQ  <= (isrQ & ~eoiHot) | ackHot;
      if (cfgWr && cfgAddr == CFG_MASK) imrQ  <= cfgData[SLICE_LINES-1:0];
      if (cfgWr && cfgAddr == CFG_BASE) baseQ <= cfgData[VEC_W-1:LINE_W];
      if (cfgWr && cfgAddr == CFG_MODE) nestQ <= cfgData[0];
    end
  end

  // Resolution against the in-service set
  always_comb begin
    pend   = irrQ & ~imrQ;
    isrEff = isrQ;
    if (IS_MASTER && nestQ) isrEff[CASCADE_LINE] = 1'b0;
    pendPick = lowestSet(pend);
    svcPick  = lowestSet(isrEff);
    hasReq   = pendPick.valid && (!svcPick.valid || pendPick.line < svcPick.line);
    winLine  = pendPick.line;
  end

  assign vecBase = baseQ;

  // R6: an acknowledged line is in service on the next clock
  p_ack_in_service_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackStb.ack && !(cfgWr && cfgAddr == CFG_EOI)) |=> isrQ[$past(ackStb.line)])
    else $error("acknowledged line not in service");

  // R11: an end-of-interrupt write clears the selected in-service bit
  p_eoi_clears_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgAddr == CFG_EOI && !ackStb.ack) |=> !isrQ[$past(cfgData[LINE_W-1:0])])
    else $error("end of interrupt did not clear");

  // R9: a masked line never wins
  p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    hasReq |-> !imrQ[winLine])
    else $error("masked line selected");

  // R2: a rising input is pending on the next clock
  for (genvar i = 0; i < SLICE_LINES; i++) begin : gEdgeChk
    p_edge_latch_r2: assert property (@(posedge clk) disable iff (!rstN)
      (reqEff[i] && !lastQ[i]) |=> irrQ[i])
      else $error("edge not latched");
  end
endmodule

// File: rtl/cascadeCtrl.sv
module cascadeCtrl
  import cascadePkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackReq,
  input  logic              mHas,
  input  logic [LINE_W-1:0] mLine,
  input  logic [BASE_W-1:0] mBase,
  input  logic              sHas,
  input  logic [LINE_W-1:0] sLine,
  input  logic [BASE_W-1:0] sBase,
  output ackStrobe_t        mStb,
  output ackStrobe_t        sStb,
  output logic              cascadeSet,
  output logic              intOut,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector,
  output logic [LINE_W:0]   ackLine
);
  logic              toSlave;
  logic [LINE_W-1:0] sPick;
  logic [VEC_W-1:0]  vecNext;
  logic [LINE_W:0]   lineNext;

  always_comb begin
    mStb.ack  = ackReq && mHas;
    mStb.line = mLine;
    toSlave   = mStb.ack && (mLine == LINE_W'(CASCADE_LINE));
    sStb.ack  = toSlave && sHas;
    sStb.line = sLine;
    sPick     = sHas ? sLine : LINE_W'(SPURIOUS_LINE);
    if (!mHas) begin
      vecNext  = {mBase, LINE_W'(SPURIOUS_LINE)};
      lineNext = {1'b0, LINE_W'(SPURIOUS_LINE)};
    end else if (mLine == LINE_W'(CASCADE_LINE)) begin
      vecNext  = {sBase, sPick};
      lineNext = {1'b1, sPick};
    end else begin
      vecNext  = {mBase, mLine};
      lineNext = {1'b0, mLine};
    end
  end

  // The cascade request is withheld in the cycle that consumes it
  assign cascadeSet = sHas && !toSlave;
  assign intOut     = mHas;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid  <= 1'b0;
      ackVector <= '0;
      ackLine   <= '0;
    end else begin
      ackValid <= ackReq;
      if (ackReq) begin
        ackVector <= vecNext;
        ackLine   <= lineNext;
      end
    end
  end

  // R6: one valid cycle per acknowledge
  p_ack_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackValid) else $error("missing valid");
  p_no_stray_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !ackValid) else $error("stray valid");

  // R8: nothing to serve gives the master spurious answer
  p_master_spurious_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && !intOut) |=>
      (ackLine == {1'b0, LINE_W'(SPURIOUS_LINE)} &&
       ackVector[LINE_W-1:0] == LINE_W'(SPURIOUS_LINE)))
    else $error("master spurious wrong");

  // R7: cascade win with an idle slave gives line 15
  p_slave_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackReq && intOut && mLine == LINE_W'(CASCADE_LINE) && !sHas) |=>
      (ackLine == {1'b1, LINE_W'(SPURIOUS_LINE)}))
    else $error("slave spurious wrong");
endmodule

// File: rtl/cascadedIrqCtrl.sv
module cascadedIrqCtrl
  import cascadePkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  logic                  mCfgWr,
  input  logic [CFG_ADDR_W-1:0] mCfgAddr,
  input  logic [VEC_W-1:0]      mCfgData,
  input  logic                  sCfgWr,
  input  logic [CFG_ADDR_W-1:0] sCfgAddr,
  input  logic [VEC_W-1:0]      sCfgData,
  input  logic                  ackReq,
  output logic                  intOut,
  output logic                  ackValid,
  output logic [VEC_W-1:0]      ackVector,
  output logic [LINE_W:0]       ackLine
);
  // Index 0 is the master, index 1 the slave
  logic                  cfgWr   [NUM_SLICES];
  logic [CFG_ADDR_W-1:0] cfgAddr [NUM_SLICES];
  logic [VEC_W-1:0]      cfgData [NUM_SLICES];
  ackStrobe_t            stb     [NUM_SLICES];
  logic                  has     [NUM_SLICES];
  logic [LINE_W-1:0]     win     [NUM_SLICES];
  logic [BASE_W-1:0]     base    [NUM_SLICES];
  logic                  cascadeSet;

  assign cfgWr[0]   = mCfgWr;
  assign cfgAddr[0] = mCfgAddr;
  assign cfgData[0] = mCfgData;
  assign cfgWr[1]   = sCfgWr;
  assign cfgAddr[1] = sCfgAddr;
  assign cfgData[1] = sCfgData;

  for (genvar g = 0; g < NUM_SLICES; g++) begin : gSlice
    irqSlice #(.IS_MASTER(g == 0)) uSlice (
      .clk        (clk),
      .rstN       (rstN),
      .reqLines   (irqIn[g*SLICE_LINES +: SLICE_LINES]),
      .cascadeSet (cascadeSet),
      .cfgWr      (cfgWr[g]),
      .cfgAddr    (cfgAddr[g]),
      .cfgData    (cfgData[g]),
      .ackStb     (stb[g]),
      .hasReq     (has[g]),
      .winLine    (win[g]),
      .vecBase    (base[g])
    );
  end

  cascadeCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ackReq     (ackReq),
    .mHas       (has[0]),
    .mLine      (win[0]),
    .mBase      (base[0]),
    .sHas       (has[1]),
    .sLine      (win[1]),
    .sBase      (base[1]),
    .mStb       (stb[0]),
    .sStb       (stb[1]),
    .cascadeSet (cascadeSet),
    .intOut     (intOut),
    .ackValid   (ackValid),
    .ackVector  (ackVector),
    .ackLine    (ackLine)
  );
endmodule

// File: tb/tb_cascadedIrqCtrl.sv
module tb_cascadedIrqCtrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        mCfgWr = 1'b0, sCfgWr = 1'b0;
  logic [1:0]  mCfgAddr = '0, sCfgAddr = '0;
  logic [7:0]  mCfgData = '0, sCfgData = '0;
  logic        ackReq = 1'b0;
  logic        intOut, ackValid;
  logic [7:0]  ackVector;
  logic [3:0]  ackLine;

  int checkCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  // Reference state
  logic [7:0] mIrr = '0, mIsr = '0, mImr = '0, sIrr = '0, sIsr = '0, sImr = '0;
  logic [4:0] mBase = '0, sBase = '0;
  bit         nest = 1'b0;

  cascadedIrqCtrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .mCfgWr(mCfgWr), .mCfgAddr(mCfgAddr), .mCfgData(mCfgData),
    .sCfgWr(sCfgWr), .sCfgAddr(sCfgAddr), .sCfgData(sCfgData),
    .ackReq(ackReq), .intOut(intOut), .ackValid(ackValid),
    .ackVector(ackVector), .ackLine(ackLine)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int lowest(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return -1;
  endfunction

  // R3: served line must beat every in-service line
  function automatic int resolve(input logic [7:0] irr, input logic [7:0] imr,
                                 input logic [7:0] isr, input bit skip2);
    int p, s;
    logic [7:0] isrE;
    p = lowest(irr & ~imr);
    if (p < 0) return -1;
    isrE = isr;
    if (skip2) isrE[2] = 1'b0;
    s = lowest(isrE);
    if (s >= 0 && s <= p) return -1;
    return p;
  endfunction

  // R5: slave request latches master line 2
  function automatic void settle();
    if (resolve(sIrr, sImr, sIsr, 1'b0) >= 0) mIrr[2] = 1'b1;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitSettle();
    repeat (3) @(negedge clk);
  endtask

  task automatic checkInt(input string tag);
    bit exp;
    exp = resolve(mIrr, mImr, mIsr, nest) >= 0;
    check(intOut == exp, tag, int'(intOut), int'(exp));
  endtask

  task automatic cfg(input bit slave, input logic [1:0] addr, input logic [7:0] data);
    if (slave) begin sCfgWr = 1'b1; sCfgAddr = addr; sCfgData = data; end
    else begin mCfgWr = 1'b1; mCfgAddr = addr; mCfgData = data; end
    @(negedge clk);
    sCfgWr = 1'b0; mCfgWr = 1'b0;
    case (addr)
      2'd0: if (slave) sImr = data; else mImr = data;
      2'd1: if (slave) sBase = data[7:3]; else mBase = data[7:3];
      2'd2: if (!slave) nest = data[0];
      default: if (slave) sIsr[data[2:0]] = 1'b0; else mIsr[data[2:0]] = 1'b0;
    endcase
    settle();
    waitSettle();
  endtask

  task automatic pulse(input logic [15:0] pat);
    irqIn = pat;
    @(negedge clk);
    irqIn = '0;
    mIrr = mIrr | (pat[7:0] & 8'hFB);
    sIrr = sIrr | pat[15:8];
    settle();
    waitSettle();
  endtask

  // Model of one acknowledge, then drive and compare
  task automatic ackCheck(input string tag, input bit useLit,
                          input int litVec, input int litLine);
    int m, s, eVec, eLine;
    m = resolve(mIrr, mImr, mIsr, nest);
    if (m < 0) begin
      eVec = {mBase, 3'd7}; eLine = 7;
    end else begin
      mIrr[m] = 1'b0; mIsr[m] = 1'b1;
      if (m == 2) begin
        s = resolve(sIrr, sImr, sIsr, 1'b0);
        if (s >= 0) begin
          sIrr[s] = 1'b0; sIsr[s] = 1'b1;
          eVec = {sBase, 3'(s)}; eLine = s + 8;
        end else begin
          eVec = {sBase, 3'd7}; eLine = 15;
        end
      end else begin
        eVec = {mBase, 3'(m)}; eLine = m;
      end
    end
    if (useLit) begin
      check(eVec == litVec && eLine == litLine, {tag, " model"}, eVec, litVec);
      eVec = litVec; eLine = litLine;
    end
    ackReq = 1'b1;
    @(negedge clk);
    ackReq = 1'b0;
    check(ackValid == 1'b1, {tag, " R6 valid"}, int'(ackValid), 1);
    check(int'(ackVector) == eVec, {tag, " vector"}, int'(ackVector), eVec);
    check(int'(ackLine) == eLine, {tag, " line"}, int'(ackLine), eLine);
    @(negedge clk);
    check(ackValid == 1'b0, {tag, " R6 one cycle"}, int'(ackValid), 0);
    settle();
    waitSettle();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      failCnt++;
      $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = int'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(intOut == 1'b0, "R4 reset intOut", int'(intOut), 0);
    check(ackValid == 1'b0, "R6 reset valid", int'(ackValid), 0);

    // R10: low data bits dropped
    cfg(1'b0, 2'd1, 8'h27);
    cfg(1'b1, 2'd1, 8'h70);

    // R1, R4: master line
    pulse(16'h0020);
    check(intOut == 1'b1, "R4 raise", int'(intOut), 1);
    ackCheck("R1 R10 master line 5", 1'b1, 8'h25, 5);
    cfg(1'b0, 2'd3, 8'd5);

    // R5, R6: slave line
    pulse(16'h0800);
    check(intOut == 1'b1, "R5 cascade raise", int'(intOut), 1);
    ackCheck("R6 slave line 11", 1'b1, 8'h73, 11);
    cfg(1'b1, 2'd3, 8'd3);
    cfg(1'b0, 2'd3, 8'd2);
    check(intOut == 1'b0, "R4 idle", int'(intOut), 0);

    // R3, R13: priority and re-raise after end of interrupt
    pulse(16'h0050);
    ackCheck("R3 lowest wins", 1'b1, 8'h24, 4);
    check(intOut == 1'b0, "R3 lower blocked", int'(intOut), 0);
    cfg(1'b0, 2'd3, 8'd4);
    check(intOut == 1'b1, "R13 re-raise", int'(intOut), 1);
    ackCheck("R13 pending served", 1'b1, 8'h26, 6);
    cfg(1'b0, 2'd3, 8'd6);

    // R8: master spurious
    ackCheck("R8 master spurious", 1'b1, 8'h27, 7);
    check(intOut == 1'b0, "R8 no change", int'(intOut), 0);

    // R5: external line 2 ignored
    pulse(16'h0004);
    check(intOut == 1'b0, "R5 pin 2 ignored", int'(intOut), 0);

    // R9: master mask
    cfg(1'b0, 2'd0, 8'h08);
    pulse(16'h0008);
    check(intOut == 1'b0, "R9 masked", int'(intOut), 0);
    cfg(1'b0, 2'd0, 8'h00);
    check(intOut == 1'b1, "R9 unmasked", int'(intOut), 1);
    ackCheck("R9 line 3", 1'b1, 8'h23, 3);
    cfg(1'b0, 2'd3, 8'd3);

    // R9: master bit 2 blocks the slave
    cfg(1'b0, 2'd0, 8'h04);
    pulse(16'h1000);
    check(intOut == 1'b0, "R9 cascade masked", int'(intOut), 0);
    cfg(1'b0, 2'd0, 8'h00);
    check(intOut == 1'b1, "R9 cascade unmasked", int'(intOut), 1);
    ackCheck("R9 line 12", 1'b1, 8'h74, 12);
    cfg(1'b1, 2'd3, 8'd4);
    cfg(1'b0, 2'd3, 8'd2);

    // R7: slave spurious
    pulse(16'h0200);
    cfg(1'b1, 2'd0, 8'h02);
    check(intOut == 1'b1, "R7 cascade latched", int'(intOut), 1);
    ackCheck("R7 slave spurious", 1'b1, 8'h77, 15);
    cfg(1'b0, 2'd3, 8'd2);
    cfg(1'b1, 2'd0, 8'h00);
    check(intOut == 1'b1, "R7 slave resumes", int'(intOut), 1);
    ackCheck("R7 line 9", 1'b1, 8'h71, 9);
    cfg(1'b1, 2'd3, 8'd1);
    cfg(1'b0, 2'd3, 8'd2);

    // R12: nesting mode
    pulse(16'h2000);
    ackCheck("R12 outer line 13", 1'b1, 8'h75, 13);
    pulse(16'h0200);
    check(intOut == 1'b0, "R12 off blocks", int'(intOut), 0);
    cfg(1'b0, 2'd2, 8'h01);
    check(intOut == 1'b1, "R12 on nests", int'(intOut), 1);
    ackCheck("R12 inner line 9", 1'b1, 8'h71, 9);
    cfg(1'b1, 2'd3, 8'd1);
    cfg(1'b1, 2'd3, 8'd5);
    cfg(1'b0, 2'd3, 8'd2);
    cfg(1'b0, 2'd2, 8'h00);

    // R2: held line is served once
    irqIn = 16'h0040;
    mIrr[6] = 1'b1;
    waitSettle();
    ackCheck("R2 held line", 1'b1, 8'h26, 6);
    cfg(1'b0, 2'd3, 8'd6);
    check(intOut == 1'b0, "R2 no re-request", int'(intOut), 0);
    irqIn = '0;
    waitSettle();
    pulse(16'h0040);
    check(intOut == 1'b1, "R2 new edge", int'(intOut), 1);
    ackCheck("R2 second edge", 1'b1, 8'h26, 6);
    cfg(1'b0, 2'd3, 8'd6);

    // Random phase against the model
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(9, 0));
      if (op <= 3) begin
        logic [15:0] p;
        p = 16'(1) << $urandom_range(15, 0);
        if ($urandom_range(1, 0) == 1) p = p | (16'(1) << $urandom_range(15, 0));
        pulse(p);
      end else if (op <= 5) begin
        ackCheck("R6 random ack", 1'b0, 0, 0);
      end else if (op <= 7) begin
        bit sl;
        int ln;
        sl = $urandom_range(1, 0) == 1;
        ln = lowest(sl ? sIsr : mIsr);
        if (ln < 0 || $urandom_range(3, 0) == 0) ln = int'($urandom_range(7, 0));
        cfg(sl, 2'd3, 8'(ln));
      end else if (op == 8) begin
        cfg($urandom_range(1, 0) == 1, 2'd0,
            8'($urandom() & $urandom() & $urandom()));
      end else begin
        cfg(1'b0, 2'd2, 8'($urandom_range(1, 0)));
      end
      checkInt("R4 random intOut");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule